// File: doc/BRIEF.md
# Aligned Contiguous Entry Allocator

The block keeps an occupancy bit for every slot of a remapping table and hands out blocks of adjacent free slots. A caller asks for a number of slots. The block rounds that number up to a power of two, giving a block size of 2^k. It then scans block-aligned candidate positions, starting at slot 0, one candidate per clock cycle. The first candidate with no occupied slot is claimed, and the block returns the base slot and the exponent k. A release request names a base and an exponent, and the block clears that range of slots.

Each request is a one-cycle pulse taken while the block is idle. `busy_o` stays high until the single-cycle `done_o` pulse. A failed operation is flagged on `fail_o` during that pulse. A request is failed without any scan if its count is zero or if its exponent is larger than the `MAX_MASK` parameter.

Top module: `ralloc_top`

## Requirements
- R1: An allocate request (`req_op_i`=0) with a count of 0 completes one cycle after acceptance with `fail_o`=1 and marks no slot occupied.
- R2: A count of 1 gives exponent 0. A count c>1 gives exponent ceil(log2 c), so 2→1, 3→2, 5→3 and 9..16→4. `rsp_mask_o` returns the exponent.
- R3: An allocate request whose exponent exceeds `MAX_MASK` completes one cycle after acceptance with `fail_o`=1, without scanning.
- R4: The scan starts at slot 0 and steps in increments of the block size 2^k. The first candidate whose 2^k slots are all free is granted, and `rsp_base_o` returns its base.
- R5: If every aligned candidate is occupied, the scan wraps back to slot 0 and the request fails. This happens after N/2^k candidates.
- R6: A granted block has all of its slots marked occupied. Later allocations skip those slots.
- R7: A release request (`req_op_i`=1) clears the 2^`req_mask_i` slots starting at `req_base_i`. It completes two cycles after acceptance with `fail_o`=0, and the freed slots can be granted again.
- R8: `busy_o` is high from the cycle after acceptance through the cycle of the `done_o` pulse. `done_o` lasts exactly one cycle. Requests presented while busy are ignored.
- R9: One candidate is examined per cycle. An allocation granted at the candidate with ordinal j (0-based) completes j+2 cycles after acceptance. A failed scan completes N/2^k+1 cycles after acceptance.
- R10: After reset, `busy_o` and `done_o` are 0 and every slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pulse, taken only when idle |
| req_op_i | input | 1 | 0 = allocate, 1 = release |
| req_count_i | input | CNT_W | Slot count for allocate |
| req_base_i | input | IDX_W | Base slot for release |
| req_mask_i | input | MASK_W | Size exponent for release |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Failure flag, valid with done_o |
| rsp_base_o | output | IDX_W | Granted or released base slot |
| rsp_mask_o | output | MASK_W | Granted or released size exponent |

## Verification
The hardest case to reach is a scan that wraps all the way around without finding a free block while new requests arrive. To set it up, the bench fills the table completely through a chain of allocations. It then starts a one-slot allocation and presents a release of the whole table on every cycle of the 64-candidate scan. Afterwards a further allocation must still fail, which shows that the release requests were ignored. The bench also checks the exact completion cycle, because the latency reveals how many candidates the scan examined.

// File: rtl/ralloc_pkg.sv
package ralloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FREE   = 2'd2,
    ST_DONE   = 2'd3
  } state_e;

  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } op_e;
endpackage

// File: rtl/ralloc_mask.sv
module ralloc_mask #(
  parameter int CNT_W    = 7,
  parameter int MASK_W   = 3,
  parameter int MAX_MASK = 4
) (
  input  logic [CNT_W-1:0]  count_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              zero_o,
  output logic              too_big_o
);
  int m;

  always_comb begin
    m = 0;
    for (int i = 0; i < CNT_W; i++) begin
      if ((32'd1 << i) < 32'(count_i)) m = i + 1;
    end
  end

  assign mask_o    = MASK_W'(m);
  assign zero_o    = (count_i == '0);
  assign too_big_o = (m > MAX_MASK);
endmodule

// File: rtl/ralloc_run.sv
module ralloc_run #(
  parameter int N_ENTRIES = 64,
  parameter int IDX_W     = 6,
  parameter int MASK_W    = 3
) (
  input  logic [N_ENTRIES-1:0] present_i,
  input  logic [IDX_W-1:0]     base_i,
  input  logic [MASK_W-1:0]    mask_i,
  output logic [N_ENTRIES-1:0] run_o,
  output logic                 hit_o
);
  localparam int END_W = IDX_W + (1 << MASK_W) + 1;

  logic [END_W-1:0] lo, hi;

  assign lo = END_W'(base_i);
  assign hi = END_W'(base_i) + (END_W'(1) << mask_i);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_run
    assign run_o[g] = (END_W'(g) >= lo) && (END_W'(g) < hi);
  end

  assign hit_o = |(run_o & present_i);
endmodule

// File: rtl/ralloc_top.sv
module ralloc_top
  import ralloc_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int MAX_MASK  = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int CNT_W    = IDX_W + 1,
  localparam int MASK_W   = $clog2(CNT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [IDX_W-1:0]  req_base_i,
  input  logic [MASK_W-1:0] req_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [IDX_W-1:0]  rsp_base_o,
  output logic [MASK_W-1:0] rsp_mask_o
);
  state_e                 state_q;
  op_e                    op_q;
  logic [N_ENTRIES-1:0]   present_q;
  logic [IDX_W-1:0]       cand_q;
  logic [MASK_W-1:0]      mask_q;
  logic                   fail_q;

  logic [MASK_W-1:0]      calc_mask;
  logic                   cnt_zero, cnt_big;
  logic [N_ENTRIES-1:0]   run;
  logic                   hit;
  logic [IDX_W:0]         next_cand;
  logic                   accept;

  ralloc_mask #(.CNT_W(CNT_W), .MASK_W(MASK_W), .MAX_MASK(MAX_MASK)) u_mask (
    .count_i  (req_count_i),
    .mask_o   (calc_mask),
    .zero_o   (cnt_zero),
    .too_big_o(cnt_big)
  );

  ralloc_run #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .MASK_W(MASK_W)) u_run (
    .present_i(present_q),
    .base_i   (cand_q),
    .mask_i   (mask_q),
    .run_o    (run),
    .hit_o    (hit)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign next_cand = {1'b0, cand_q} + ((IDX_W+1)'(1) << mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_ALLOC;
      present_q <= '0;
      cand_q    <= '0;
      mask_q    <= '0;
      fail_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q <= op_e'(req_op_i);
          if (req_op_i == OP_FREE) begin
            cand_q  <= req_base_i;
            mask_q  <= req_mask_i;
            fail_q  <= 1'b0;
            state_q <= ST_FREE;
          end else begin
            cand_q <= '0;
            mask_q <= calc_mask;
            if (cnt_zero || cnt_big) begin
              fail_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              fail_q  <= 1'b0;
              state_q <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (!hit) begin
            present_q <= present_q | run;
            state_q   <= ST_DONE;
          end else if (next_cand[IDX_W-1:0] == '0) begin
            // wrapped to the start index: table exhausted
            fail_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            cand_q <= next_cand[IDX_W-1:0];
          end
        end
        ST_FREE: begin
          present_q <= present_q & ~run;
          state_q   <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign fail_o     = done_o && fail_q;
  assign rsp_base_o = cand_q;
  assign rsp_mask_o = mask_q;

  // R1
  zero_count_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_op_i && req_count_i == '0) |=> (done_o && fail_o && $stable(present_q)));

  // R3
  big_mask_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_op_i && cnt_big) |=> (done_o && fail_o));

  // R4
  aligned_cand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> ((cand_q & ((IDX_W'(1) << mask_q) - IDX_W'(1))) == '0));

  // R6
  grant_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o && op_q == OP_ALLOC) |-> ((present_q & run) == run));

  // R7
  free_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_FREE) |-> ((present_q & run) == '0));

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
endmodule

// File: tb/ralloc_top_tb.sv
module ralloc_top_tb;
  localparam int N_ENTRIES = 64;
  localparam int MAX_MASK  = 4;
  localparam int IDX_W     = 6;
  localparam int CNT_W     = 7;
  localparam int MASK_W    = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_op_i = 1'b0;
  logic [CNT_W-1:0]  req_count_i = '0;
  logic [IDX_W-1:0]  req_base_i = '0;
  logic [MASK_W-1:0] req_mask_i = '0;
  logic              busy_o, done_o, fail_o;
  logic [IDX_W-1:0]  rsp_base_o;
  logic [MASK_W-1:0] rsp_mask_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  ralloc_top #(.N_ENTRIES(N_ENTRIES), .MAX_MASK(MAX_MASK)) u_dut (.*);

  typedef struct packed {
    logic              op;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  b;
    logic [MASK_W-1:0] m;
    logic              ef;
    logic [IDX_W-1:0]  eb;
    logic [MASK_W-1:0] em;
    logic [7:0]        lat;
    logic [7:0]        req;
  } vec_t;

  // op, count, base, mask, exp fail, exp base, exp mask, exp latency, requirement
  localparam vec_t VEC [16] = '{
    '{1'b0, 7'd1,  6'd0,  3'd0, 1'b0, 6'd0,  3'd0, 8'd2,  8'd4},  // R4 first slot
    '{1'b0, 7'd3,  6'd0,  3'd0, 1'b0, 6'd4,  3'd2, 8'd3,  8'd2},  // R2 3->2, stride 4
    '{1'b0, 7'd0,  6'd0,  3'd0, 1'b1, 6'd0,  3'd0, 8'd1,  8'd1},  // R1 zero count
    '{1'b0, 7'd17, 6'd0,  3'd0, 1'b1, 6'd0,  3'd0, 8'd1,  8'd3},  // R3 mask 5 > 4
    '{1'b0, 7'd2,  6'd0,  3'd0, 1'b0, 6'd2,  3'd1, 8'd3,  8'd6},  // R6 skip slot 0
    '{1'b0, 7'd16, 6'd0,  3'd0, 1'b0, 6'd16, 3'd4, 8'd3,  8'd4},  // R4 stride 16
    '{1'b0, 7'd5,  6'd0,  3'd0, 1'b0, 6'd8,  3'd3, 8'd3,  8'd2},  // R2 5->3
    '{1'b1, 7'd0,  6'd0,  3'd0, 1'b0, 6'd0,  3'd0, 8'd2,  8'd7},  // R7 free slot 0
    '{1'b0, 7'd1,  6'd0,  3'd0, 1'b0, 6'd0,  3'd0, 8'd2,  8'd7},  // R7 slot 0 reusable
    '{1'b0, 7'd1,  6'd0,  3'd0, 1'b0, 6'd1,  3'd0, 8'd3,  8'd9},  // R9
    '{1'b0, 7'd16, 6'd0,  3'd0, 1'b0, 6'd32, 3'd4, 8'd4,  8'd9},  // R9 third candidate
    '{1'b0, 7'd16, 6'd0,  3'd0, 1'b0, 6'd48, 3'd4, 8'd5,  8'd9},  // R9 fourth candidate
    '{1'b0, 7'd1,  6'd0,  3'd0, 1'b1, 6'd0,  3'd0, 8'd65, 8'd5},  // R5 full sweep fails
    '{1'b1, 7'd0,  6'd16, 3'd4, 1'b0, 6'd16, 3'd4, 8'd2,  8'd7},  // R7 free 16..31
    '{1'b0, 7'd9,  6'd0,  3'd0, 1'b0, 6'd16, 3'd4, 8'd3,  8'd2},  // R2 9->4, reuse
    '{1'b1, 7'd0,  6'd8,  3'd3, 1'b0, 6'd8,  3'd3, 8'd2,  8'd7}   // R7 free 8..15
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [CNT_W-1:0] cnt,
                        input logic [IDX_W-1:0] b, input logic [MASK_W-1:0] m,
                        input logic ef, input logic [IDX_W-1:0] eb,
                        input logic [MASK_W-1:0] em, input int elat, input string req);
    int lat;
    @(negedge clk_i);
    req_op_i = op; req_count_i = cnt; req_base_i = b; req_mask_i = m;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!done_o && lat < 200);
    check(lat == elat, req, "latency", lat, elat);
    check(fail_o == ef, req, "fail", int'(fail_o), int'(ef));
    if (!ef) begin
      check(rsp_base_o == eb, req, "base", int'(rsp_base_o), int'(eb));
      check(rsp_mask_o == em, req, "mask", int'(rsp_mask_o), int'(em));
    end
    check(busy_o == 1'b1, "R8", "busy at done", int'(busy_o), 1);
    @(negedge clk_i);
    check(done_o == 1'b0 && busy_o == 1'b0, "R8", "done one cycle", int'(done_o), 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(busy_o == 1'b0, "R10", "busy in reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R10", "done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < 16; i++) begin
      run_op(VEC[i].op, VEC[i].cnt, VEC[i].b, VEC[i].m, VEC[i].ef, VEC[i].eb,
             VEC[i].em, int'(VEC[i].lat), $sformatf("R%0d", VEC[i].req));
    end
    // R6 slots 8..15 free again, 0..7 still held: count 4 lands at 8
    run_op(1'b0, 7'd4, 6'd0, 3'd0, 1'b0, 6'd8, 3'd2, 4, "R6");

    // R10 reset clears the table
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle after reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    run_op(1'b0, 7'd16, 6'd0, 3'd0, 1'b0, 6'd0, 3'd4, 2, "R10");
    run_op(1'b0, 7'd16, 6'd0, 3'd0, 1'b0, 6'd16, 3'd4, 3, "R4");
    run_op(1'b0, 7'd16, 6'd0, 3'd0, 1'b0, 6'd32, 3'd4, 4, "R4");
    run_op(1'b0, 7'd16, 6'd0, 3'd0, 1'b0, 6'd48, 3'd4, 5, "R4");

    // R8 requests during a long failing scan are ignored
    @(negedge clk_i);
    req_op_i = 1'b0; req_count_i = 7'd1; req_valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    req_op_i = 1'b1; req_base_i = 6'd0; req_mask_i = 3'd6;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
      if (lat == 30) check(busy_o == 1'b1, "R8", "busy mid scan", int'(busy_o), 1);
    end while (!done_o && lat < 200);
    req_valid_i = 1'b0;
    check(lat == 65, "R5", "wrap latency", lat, 65);
    check(fail_o == 1'b1, "R5", "wrap fail", int'(fail_o), 1);
    @(negedge clk_i);
    // R8 table must still be full
    run_op(1'b0, 7'd16, 6'd0, 3'd0, 1'b1, 6'd0, 3'd0, 5, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule